// File: doc/BRIEF.md
# Serial Burst-Correcting Code Encoder

This block turns a stream of 265 information bits into a 279-bit systematic code word for a cyclic code that corrects bursts. The code's generator is g(X) = X^14 + X^11 + X^9 + X^5 + X^2 + 1, which is the product (X^5 + X^2 + 1)(X^9 + 1). Each information bit is forwarded to the channel output without change. The same bit also drives a 14-stage division register, so the remainder builds up while the data streams through.

After the last information bit, the division feedback is switched off. The register then empties onto the channel as 14 check bits, and this completes the word. A one-cycle start pulse opens each block. The source may hold back data by lowering its valid strobe during the information phase. The flush phase runs on its own and takes nothing from the source.

Top module: `fire_enc`

## Requirements
- R1: After reset, `dout_vld_o` and `busy_o` are low.
- R2: In the information phase, every cycle with `din_vld_i` high emits that bit on `dout_o`, unchanged, with `dout_vld_o` high one clock later. A cycle with `din_vld_i` low gives `dout_vld_o` low one clock later and does not count toward the 265 bits.
- R3: The 265th accepted information bit is followed by 14 consecutive output cycles with `dout_vld_o` high. These cycles carry the check bits, and no input strobe is needed to produce them.
- R4: The first information bit accepted is the coefficient of X^264 in the message polynomial m(X). The check bits are the remainder of m(X)·X^14 divided by g(X), emitted from the X^13 coefficient down to the X^0 coefficient.
- R5: The 279 emitted bits, read with the first bit as the coefficient of X^278, form a polynomial that g(X) divides exactly.
- R6: `busy_o` rises on the clock after a start pulse. It stays high until the clock edge that presents the last check bit, and it falls on that edge.
- R7: A start pulse clears the division register and restarts the count, even in the middle of a block. A `din_vld_i` raised in the same cycle as the start pulse is ignored.
- R8: `din_i` and `din_vld_i` have no effect during the check phase or while idle. No output is produced while idle.
- R9: The division taps are X^11, X^9, X^5, X^2 and X^0. A message of value 1 therefore yields check bits 0x0A25, and a message of value 2 yields 0x144A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that opens a new block |
| din_i | input | 1 | Information bit |
| din_vld_i | input | 1 | Qualifies `din_i` during the information phase |
| dout_o | output | 1 | Channel bit |
| dout_vld_o | output | 1 | Qualifies `dout_o` |
| busy_o | output | 1 | High while a block is in progress |

## Verification
The hardest condition to reach from the ports is a source that keeps its strobe high and drives changing data through the check phase. The bench does this on purpose, and any leak of input into the flush would corrupt the check bits and the zero-remainder test. A second hard case is a start pulse, with a simultaneous strobe, landing in the middle of a partly encoded block. The bench forces it after 100 bits and then confirms that the following word is clean. Finally, the bench sweeps a single one through all 265 information positions, so every power X^14..X^278 modulo g(X) is compared against an independent long division.

// File: rtl/fire_enc_pkg.sv
package fire_enc_pkg;

    // Default code geometry: 265 information bits, 14 check bits.
    localparam int unsigned INFO_BITS_DEF  = 265;
    localparam int unsigned CHECK_BITS_DEF = 14;

    // Low-order generator coefficients; the X^CHECK_BITS term is implicit.
    // X^11 + X^9 + X^5 + X^2 + 1
    localparam logic [CHECK_BITS_DEF-1:0] GEN_TAPS_DEF = 14'h0A25;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_INFO  = 2'd1,
        PH_FLUSH = 2'd2
    } phase_e;

    // One symbol handed to the channel.
    typedef struct packed {
        logic vld;
        logic bit_val;
    } chan_sym_t;

    // Shift commands from the sequencer to the datapath.
    typedef struct packed {
        logic clear;
        logic info_shift;
        logic flush_shift;
    } shift_cmd_t;

endpackage

// File: rtl/fire_enc_seq.sv
module fire_enc_seq
    import fire_enc_pkg::*;
#(
    parameter int unsigned INFO_BITS  = INFO_BITS_DEF,
    parameter int unsigned CHECK_BITS = CHECK_BITS_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       din_vld_i,
    output phase_e     phase_o,
    output shift_cmd_t cmd_o
);

    localparam int unsigned SPAN  = (INFO_BITS > CHECK_BITS) ? INFO_BITS : CHECK_BITS;
    localparam int unsigned CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [CNT_W-1:0] INFO_LAST  = CNT_W'(INFO_BITS - 1);
    localparam logic [CNT_W-1:0] CHECK_LAST = CNT_W'(CHECK_BITS - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] idx;
    } seq_state_t;

    seq_state_t st_q, st_d;

    // Shift commands: a start pulse overrides everything else.
    always_comb begin
        cmd_o.clear       = start_i;
        cmd_o.info_shift  = !start_i && (st_q.phase == PH_INFO) && din_vld_i;
        cmd_o.flush_shift = !start_i && (st_q.phase == PH_FLUSH);
    end

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.phase = PH_INFO;
            st_d.idx   = '0;
        end else begin
            unique case (st_q.phase)
                PH_INFO: begin
                    if (din_vld_i) begin
                        if (st_q.idx == INFO_LAST) begin
                            st_d.phase = PH_FLUSH;
                            st_d.idx   = '0;
                        end else begin
                            st_d.idx = st_q.idx + 1'b1;
                        end
                    end
                end
                PH_FLUSH: begin
                    if (st_q.idx == CHECK_LAST) begin
                        st_d.phase = PH_IDLE;
                        st_d.idx   = '0;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.idx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= PH_IDLE;
            st_q.idx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;

    AST_START_ENTERS_INFO: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (st_q.phase == PH_INFO && st_q.idx == '0))
        else $error("start did not open information phase"); // R7

    AST_GAP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_INFO && !din_vld_i && !start_i) |=> $stable(st_q.idx))
        else $error("count moved without valid input"); // R2

    AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_FLUSH && st_q.idx == CHECK_LAST && !start_i) |=> (st_q.phase == PH_IDLE))
        else $error("check phase overran"); // R6

    AST_INFO_TO_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_INFO && st_q.idx == INFO_LAST && din_vld_i && !start_i) |=> (st_q.phase == PH_FLUSH))
        else $error("check phase not entered after last bit"); // R3

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase == PH_FLUSH) |-> (st_q.idx <= CHECK_LAST))
        else $error("flush index out of range"); // R3

endmodule

// File: rtl/fire_enc_rem.sv
module fire_enc_rem
    import fire_enc_pkg::*;
#(
    parameter int unsigned           CHECK_BITS = CHECK_BITS_DEF,
    parameter logic [CHECK_BITS-1:0] GEN_TAPS   = GEN_TAPS_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  shift_cmd_t cmd_i,
    input  logic       din_i,
    output logic       msb_o
);

    localparam int unsigned MSB = CHECK_BITS - 1;

    logic [CHECK_BITS-1:0] rem_q, rem_d;
    logic fb;
    logic feed;

    // Feedback: the outgoing stage combined with the incoming bit.
    // It is active only while information bits are being divided.
    assign fb   = rem_q[MSB] ^ din_i;
    assign feed = cmd_i.info_shift & fb;

    for (genvar s = 0; s < CHECK_BITS; s++) begin : g_stage
        if (s == 0) begin : g_low
            if (GEN_TAPS[0]) begin : g_tap
                assign rem_d[0] = feed;
            end else begin : g_notap
                assign rem_d[0] = 1'b0;
            end
        end else begin : g_mid
            if (GEN_TAPS[s]) begin : g_tap
                assign rem_d[s] = rem_q[s-1] ^ feed;
            end else begin : g_notap
                assign rem_d[s] = rem_q[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
        end else if (cmd_i.clear) begin
            rem_q <= '0;
        end else if (cmd_i.info_shift || cmd_i.flush_shift) begin
            rem_q <= rem_d;
        end
    end

    assign msb_o = rem_q[MSB];

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        cmd_i.clear |=> (rem_q == '0))
        else $error("remainder not cleared by start"); // R7

    AST_FLUSH_NO_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
        cmd_i.flush_shift |=> (rem_q[MSB:1] == $past(rem_q[MSB-1:0]) && !rem_q[0]))
        else $error("feedback active during check phase"); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!cmd_i.clear && !cmd_i.info_shift && !cmd_i.flush_shift) |=> $stable(rem_q))
        else $error("remainder changed without command"); // R8

endmodule

// File: rtl/fire_enc_mux.sv
module fire_enc_mux
    import fire_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  shift_cmd_t cmd_i,
    input  logic       din_i,
    input  logic       rem_msb_i,
    output chan_sym_t  sym_o
);

    chan_sym_t sym_d;

    always_comb begin
        sym_d.vld = cmd_i.info_shift | cmd_i.flush_shift;
        if (cmd_i.info_shift) begin
            sym_d.bit_val = din_i;
        end else if (cmd_i.flush_shift) begin
            sym_d.bit_val = rem_msb_i;
        end else begin
            sym_d.bit_val = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_o <= '0;
        end else begin
            sym_o <= sym_d;
        end
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_i.info_shift, cmd_i.flush_shift}))
        else $error("both output sources selected"); // R3

    AST_FLUSH_BIT: assert property (@(posedge clk) disable iff (rst)
        cmd_i.flush_shift |=> (sym_o.vld && sym_o.bit_val == $past(rem_msb_i)))
        else $error("check bit not taken from register top"); // R4

endmodule

// File: rtl/fire_enc.sv
module fire_enc
    import fire_enc_pkg::*;
#(
    parameter int unsigned           INFO_BITS  = INFO_BITS_DEF,
    parameter int unsigned           CHECK_BITS = CHECK_BITS_DEF,
    parameter logic [CHECK_BITS-1:0] GEN_TAPS   = GEN_TAPS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic din_i,
    input  logic din_vld_i,
    output logic dout_o,
    output logic dout_vld_o,
    output logic busy_o
);

    phase_e     phase;
    shift_cmd_t cmd;
    logic       rem_msb;
    chan_sym_t  sym;

    fire_enc_seq #(
        .INFO_BITS  (INFO_BITS),
        .CHECK_BITS (CHECK_BITS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .din_vld_i (din_vld_i),
        .phase_o   (phase),
        .cmd_o     (cmd)
    );

    fire_enc_rem #(
        .CHECK_BITS (CHECK_BITS),
        .GEN_TAPS   (GEN_TAPS)
    ) u_rem (
        .clk   (clk),
        .rst   (rst),
        .cmd_i (cmd),
        .din_i (din_i),
        .msb_o (rem_msb)
    );

    fire_enc_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .din_i     (din_i),
        .rem_msb_i (rem_msb),
        .sym_o     (sym)
    );

    assign dout_o     = sym.bit_val;
    assign dout_vld_o = sym.vld;
    assign busy_o     = (phase != PH_IDLE);

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INFO && din_vld_i && !start_i) |=> (dout_vld_o && dout_o == $past(din_i)))
        else $error("information bit not forwarded"); // R2

    AST_GAP_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_INFO && !din_vld_i) |=> !dout_vld_o)
        else $error("output during input gap"); // R2

    AST_FLUSH_VALID: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FLUSH && !start_i) |=> dout_vld_o)
        else $error("check bit missing"); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> !dout_vld_o)
        else $error("output while idle"); // R8

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o)
        else $error("busy not raised by start"); // R6

endmodule

// File: tb/tb_fire_enc.sv
`timescale 1ns/1ps
module tb_fire_enc;

    localparam int K = 265;
    localparam int R = 14;
    localparam int N = K + R;
    localparam logic [R:0] GFULL = 15'h4A25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic din_i = 1'b0;
    logic din_vld_i = 1'b0;
    logic dout_o, dout_vld_o, busy_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #2.5 clk = ~clk;

    fire_enc dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .din_i      (din_i),
        .din_vld_i  (din_vld_i),
        .dout_o     (dout_o),
        .dout_vld_o (dout_vld_o),
        .busy_o     (busy_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Long division of a 279-bit word (bit N-1 is the highest power) by g(X).
    function automatic logic [R-1:0] mod_g(input logic [N-1:0] word);
        logic [R:0] r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            r = {r[R-1:0], word[i]};
            if (r[R]) r = r ^ GFULL;
        end
        return r[R-1:0];
    endfunction

    logic [R-1:0] last_chk;

    task automatic run_block(input logic [K-1:0] msg, input int gap, input bit noise,
                             input bit start_vld, input string name);
        logic [N-1:0] cap = '0;
        int vbad = 0;
        int bbad = 0;
        logic [R-1:0] exp_chk;
        @(negedge clk);
        start_i = 1'b1; din_vld_i = start_vld; din_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R7: strobe in the start cycle produces nothing; R6: busy raised
        if (dout_vld_o !== 1'b0) vbad++;
        if (busy_o !== 1'b1) bbad++;
        for (int i = 0; i < K; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) begin
                din_vld_i = 1'b0; din_i = ~msg[K-1-i];
                @(negedge clk);
                if (dout_vld_o !== 1'b0) vbad++;
                if (busy_o !== 1'b1) bbad++;
            end
            din_i = msg[K-1-i]; din_vld_i = 1'b1;
            @(negedge clk);
            if (dout_vld_o !== 1'b1) vbad++;
            if (busy_o !== 1'b1) bbad++;
            cap[N-1-i] = dout_o;
        end
        for (int j = 0; j < R; j++) begin
            rng = next_rand(rng);
            din_vld_i = noise; din_i = noise ? rng[7] : 1'b0;
            @(negedge clk);
            if (dout_vld_o !== 1'b1) vbad++;
            if (busy_o !== (j < R - 1)) bbad++;
            cap[R-1-j] = dout_o;
        end
        din_vld_i = noise; din_i = 1'b1;
        @(negedge clk);
        if (dout_vld_o !== 1'b0) vbad++;
        if (busy_o !== 1'b0) bbad++;
        din_vld_i = 1'b0; din_i = 1'b0;
        exp_chk = mod_g({msg, {R{1'b0}}});
        last_chk = cap[R-1:0];
        chk(cap[N-1:R] == msg, {"R2 data pass-through ", name}, N'(cap[N-1:R]), N'(msg));
        chk(cap[R-1:0] == exp_chk, {"R4 check bits ", name}, N'(cap[R-1:0]), N'(exp_chk));
        chk(mod_g(cap) == '0, {"R5 word remainder ", name}, N'(mod_g(cap)), '0);
        chk(vbad == 0, {"R3 output valid pattern ", name}, N'(vbad), '0);
        chk(bbad == 0, {"R6 busy timing ", name}, N'(bbad), '0);
    endtask

    function automatic logic [K-1:0] rand_msg(input logic [31:0] seed);
        logic [K-1:0] m = '0;
        logic [31:0] s = seed;
        for (int i = 0; i < K; i++) begin
            s = next_rand(s);
            m[i] = s[3];
        end
        return m;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int idle_bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dout_vld_o === 1'b0, "R1 reset valid", N'(dout_vld_o), '0);
        chk(busy_o === 1'b0, "R1 reset busy", N'(busy_o), '0);

        // R8: input while idle is ignored
        idle_bad = 0;
        for (int i = 0; i < 6; i++) begin
            din_vld_i = 1'b1; din_i = i[0];
            @(negedge clk);
            if (dout_vld_o !== 1'b0 || busy_o !== 1'b0) idle_bad++;
        end
        din_vld_i = 1'b0;
        chk(idle_bad == 0, "R8 idle input ignored", N'(idle_bad), '0);

        // R9: known remainders of X^14 and X^15
        run_block(K'(1), 0, 1'b0, 1'b0, "msg=1");
        chk(last_chk == 14'h0A25, "R9 taps X^14", N'(last_chk), N'(14'h0A25));
        run_block(K'(2), 0, 1'b0, 1'b0, "msg=2");
        chk(last_chk == 14'h144A, "R9 taps X^15", N'(last_chk), N'(14'h144A));

        run_block('0, 0, 1'b0, 1'b0, "zeros");
        run_block('1, 0, 1'b0, 1'b0, "ones");
        // R8: strobe and data active during the check phase
        run_block(rand_msg(32'hCAFE_0001), 0, 1'b1, 1'b0, "noise in flush");
        // R2: gaps in the strobe
        run_block(rand_msg(32'hCAFE_0002), 7, 1'b0, 1'b0, "gaps");
        run_block(rand_msg(32'hCAFE_0003), 3, 1'b1, 1'b0, "gaps+noise");

        // R7: abandon a block after 100 bits, restart with a strobe in the start cycle
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 100; i++) begin
            din_vld_i = 1'b1; din_i = 1'b1;
            @(negedge clk);
        end
        din_vld_i = 1'b0;
        run_block(rand_msg(32'hCAFE_0004), 0, 1'b0, 1'b1, "R7 restart mid-block");

        // Sweep: single one at each information position
        for (int p = 0; p < K; p++) begin
            logic [K-1:0] m = '0;
            m[p] = 1'b1;
            run_block(m, 0, p[0], 1'b0, $sformatf("single one at %0d", p));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule